// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Protected Memory

This block is a synchronous memory that guards every stored word against bit upsets. The write bus is split into 64-bit lanes. Each lane gets its own 8 check bits before it enters the array: seven Hamming parity bits and one parity bit over the whole 72-bit codeword. On a read, each lane is decoded on its own. A single flipped bit is repaired before the data reaches the output. Two flipped bits are reported as an uncorrectable error.

Two injection inputs on the write port corrupt the word being stored. Firmware bring-up and system tests can use them to force the correction and detection paths and to see the flags fire on the matching read. The read side has a fixed two-cycle latency. The array is sampled on the first edge, and the decoded data and flags are registered on the second edge, together with a valid strobe. The flags cover the whole word and are raised if any lane reports that condition.

Top module: `secded_ram`

## Requirements
- R1: The data width is a whole multiple of 64 bits. Each 64-bit lane is encoded and decoded separately, so an uncorrectable error in lane 0 leaves the data of all higher lanes correct on the same read.
- R2: A word written with neither injection input asserted reads back unchanged, with `err_single` = 0 and `err_double` = 0.
- R3: A word written with `inj_single` = 1 has data bit 0 of lane 0 inverted in storage. Its read returns the original data fully corrected, with `err_single` = 1 and `err_double` = 0.
- R4: A word written with `inj_double` = 1 has data bits 0 and 1 of lane 0 inverted in storage. Its read gives `err_double` = 1 and `err_single` = 0.
- R5: When `inj_single` and `inj_double` are both 1 on a write, the double-bit injection applies, and the read reports as in R4.
- R6: `rd_valid` is 1 exactly two rising edges after an edge that sampled `rd_en` = 1. Data and flags are presented in that same cycle. Both flags are 0 whenever `rd_valid` is 0, and the two flags are never 1 together.
- R7: While `rst` is 1 (synchronous, active high), `rd_valid`, `err_single` and `err_double` are 0 from the next edge on.
- R8: A read and a write to the same address on the same edge return the contents held before that write.
- R9: Injection affects only the write it accompanies. A later clean write to the same address reads back with both flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the read pipeline |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| inj_single | input | 1 | Store the word with one data bit of lane 0 inverted |
| inj_double | input | 1 | Store the word with two data bits of lane 0 inverted (has priority) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Corrected read data |
| rd_valid | output | 1 | Read data valid, two edges after the request |
| err_single | output | 1 | A single-bit error was corrected in the presented word |
| err_double | output | 1 | An uncorrectable error was detected in the presented word |

## Verification
The checker checks three properties on every cycle: the two-edge spacing between a read request and its valid strobe, that the flags stay quiet outside valid cycles and are never raised together, and that reset clears the read outputs. Only the bench's scenarios can show that data comes back corrected, and that injection changes the flags on the matching read and on no other read. They also show that higher lanes survive a lane-0 double error, that double injection wins over single injection, and that a read on the same edge as a write returns the old data. These depend on what was stored and when, which a property over the ports cannot track.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int LANE_W = 64;
    localparam int CW_W   = 72;
    localparam int SYN_W  = 7;

    typedef logic [CW_W-1:0] cw_t;

    typedef struct packed {
        logic [LANE_W-1:0] data;
        logic              single;
        logic              dbl;
    } lane_res_t;

    function automatic logic is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Codeword layout: bit 0 = overall parity, bits 1..71 = Hamming positions.
    function automatic cw_t encode(input logic [LANE_W-1:0] d);
        cw_t cw;
        int  k;
        cw = '0;
        k  = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                cw[p[6:0]] = d[k[5:0]];
                k++;
            end
        end
        for (int j = 0; j < SYN_W; j++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p < CW_W; p++) begin
                if (p[j] && !is_pow2(p)) x ^= cw[p[6:0]];
            end
            cw[7'(1 << j)] = x;
        end
        cw[0] = ^cw[CW_W-1:1];
        return cw;
    endfunction

    function automatic lane_res_t decode(input cw_t cw);
        logic [SYN_W-1:0] syn;
        logic             ov;
        cw_t              fx;
        lane_res_t        r;
        int               k;
        syn = '0;
        for (int p = 1; p < CW_W; p++) begin
            if (cw[p[6:0]]) syn ^= p[6:0];
        end
        ov       = ^cw;
        fx       = cw;
        r.single = 1'b0;
        r.dbl    = 1'b0;
        if (ov) begin
            if (syn < 7'd72) begin
                fx[syn]  = ~fx[syn];
                r.single = 1'b1;
            end else begin
                r.dbl = 1'b1;
            end
        end else if (syn != '0) begin
            r.dbl = 1'b1;
        end
        r.data = '0;
        k      = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                r.data[k[5:0]] = fx[p[6:0]];
                k++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic [LANES*LANE_W-1:0] data,
    input  logic                    inj_single,
    input  logic                    inj_double,
    output logic [LANES*CW_W-1:0]   cw
);
    // Data bit 0 sits at position 3, data bit 1 at position 5.
    localparam logic [CW_W-1:0] MASK_ONE = CW_W'(1) << 3;
    localparam logic [CW_W-1:0] MASK_TWO = (CW_W'(1) << 3) | (CW_W'(1) << 5);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cw_t clean;
        always_comb clean = encode(data[g*LANE_W +: LANE_W]);
        if (g == 0) begin : g_inj
            always_comb begin
                if (inj_double)      cw[g*CW_W +: CW_W] = clean ^ MASK_TWO;
                else if (inj_single) cw[g*CW_W +: CW_W] = clean ^ MASK_ONE;
                else                 cw[g*CW_W +: CW_W] = clean;
            end
        end else begin : g_plain
            assign cw[g*CW_W +: CW_W] = clean;
        end
    end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import secded_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic [LANES*CW_W-1:0]   cw,
    output logic [LANES*LANE_W-1:0] data,
    output logic                    any_single,
    output logic                    any_double
);
    logic [LANES-1:0] sgl;
    logic [LANES-1:0] dbl;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_res_t res;
        always_comb res = decode(cw[g*CW_W +: CW_W]);
        assign data[g*LANE_W +: LANE_W] = res.data;
        assign sgl[g] = res.single;
        assign dbl[g] = res.dbl;
    end

    assign any_single = |sgl;
    assign any_double = |dbl;
endmodule

// File: rtl/secded_store.sv
module secded_store #(
    parameter int WIDTH  = 144,
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/secded_ram.sv
module secded_ram
    import secded_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int DEPTH  = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inj_single,
    input  logic              inj_double,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              err_single,
    output logic              err_double
);
    localparam int LANES   = DATA_W / LANE_W;
    localparam int STORE_W = LANES * CW_W;

    if (DATA_W % LANE_W != 0 || DATA_W == 0) begin : g_bad_width
        $error("DATA_W must be a nonzero multiple of 64");
    end

    typedef struct packed {
        logic              s1_valid;
        logic              out_valid;
        logic [DATA_W-1:0] out_data;
        logic              out_single;
        logic              out_double;
    } state_t;

    state_t st_d, st_q;

    logic [STORE_W-1:0] wr_cw;
    logic [STORE_W-1:0] rd_cw;
    logic [DATA_W-1:0]  dec_data;
    logic               dec_single;
    logic               dec_double;

    secded_enc #(.LANES(LANES)) u_enc (
        .data       (wr_data),
        .inj_single (inj_single),
        .inj_double (inj_double),
        .cw         (wr_cw)
    );

    secded_store #(.WIDTH(STORE_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_cw),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (rd_cw)
    );

    secded_dec #(.LANES(LANES)) u_dec (
        .cw         (rd_cw),
        .data       (dec_data),
        .any_single (dec_single),
        .any_double (dec_double)
    );

    always_comb begin
        st_d           = st_q;
        st_d.s1_valid  = rd_en;
        st_d.out_valid = st_q.s1_valid;
        if (st_q.s1_valid) begin
            st_d.out_data   = dec_data;
            st_d.out_single = dec_single;
            st_d.out_double = dec_double;
        end else begin
            st_d.out_single = 1'b0;
            st_d.out_double = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rd_data    = st_q.out_data;
    assign rd_valid   = st_q.out_valid;
    assign err_single = st_q.out_single;
    assign err_double = st_q.out_double;
endmodule

// File: rtl/secded_ram_chk.sv
module secded_ram_chk (
    input logic clk,
    input logic rst,
    input logic rd_en,
    input logic rd_valid,
    input logic err_single,
    input logic err_double
);
    logic [1:0] cyc_q;

    always_ff @(posedge clk) begin
        if (rst)               cyc_q <= '0;
        else if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
    end

    // R6: valid follows a sampled request by two edges
    a_r6_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (cyc_q == 2'd2) |-> (rd_valid == $past(rd_en, 2)));

    // R6: flags only accompany valid data
    a_r6_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (!err_single && !err_double));

    // R6: corrected and uncorrectable are exclusive
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(err_single && err_double));

    // R7: reset clears the read outputs
    a_r7_reset_quiet: assert property (@(posedge clk)
        rst |=> (!rd_valid && !err_single && !err_double));
endmodule

bind secded_ram secded_ram_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .rd_valid   (rd_valid),
    .err_single (err_single),
    .err_double (err_double)
);

// File: tb/secded_ram_test.sv
module secded_ram_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 128;
    localparam int DEPTH      = 32;
    localparam int AW         = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          inj_single = 1'b0;
    logic          inj_double = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          err_single;
    logic          err_double;

    secded_ram #(.DATA_W(DW), .DEPTH(DEPTH)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit            v;
        logic [DW-1:0] d;
        int            kind;
        string         tag;
    } exp_t;

    exp_t          q[$];
    logic [DW-1:0] mdata [DEPTH];
    int            mkind [DEPTH];
    int            n_cmp = 0;
    int            n_bad = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input exp_t e);
        chk(rd_valid == e.v, e.v ? "R6" : e.tag, "rd_valid", DW'(rd_valid), DW'(e.v));
        if (e.v) begin
            chk(err_single == (e.kind == 1), e.tag, "err_single", DW'(err_single), DW'(e.kind == 1));
            chk(err_double == (e.kind == 2), e.tag, "err_double", DW'(err_double), DW'(e.kind == 2));
            if (e.kind == 2)
                chk(rd_data[DW-1:64] == e.d[DW-1:64], "R1", "upper lanes", rd_data, e.d);
            else
                chk(rd_data == e.d, e.tag, "rd_data", rd_data, e.d);
        end else begin
            chk(!err_single && !err_double, "R6", "idle flags", DW'({err_single, err_double}), '0);
        end
    endtask

    task automatic step(input bit we, input int wa, input logic [DW-1:0] wd,
                        input bit is, input bit id, input bit re, input int ra,
                        input string tag);
        exp_t e;
        @(negedge clk);
        compare(q.pop_front());
        wr_en      = we;
        wr_addr    = AW'(wa);
        wr_data    = wd;
        inj_single = is;
        inj_double = id;
        rd_en      = re;
        rd_addr    = AW'(ra);
        e.v   = re;
        e.d   = re ? mdata[ra] : '0;
        e.kind = re ? mkind[ra] : 0;
        e.tag = tag;
        if (we) begin
            mdata[wa] = wd;
            mkind[wa] = id ? 2 : (is ? 1 : 0);
        end
        q.push_back(e);
    endtask

    function automatic logic [DW-1:0] rnd();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, 0, 0, 0, 0, "R6");
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        exp_t z;
        z.v = 0; z.d = '0; z.kind = 0; z.tag = "R6";
        for (int i = 0; i < DEPTH; i++) begin mdata[i] = '0; mkind[i] = 0; end
        rd_en = 1'b1;
        repeat (3) @(negedge clk);
        // R7: outputs quiet during reset
        chk(!rd_valid && !err_single && !err_double, "R7", "reset outputs",
            DW'({rd_valid, err_single, err_double}), '0);
        rd_en = 1'b0;
        rst   = 1'b0;
        q.push_back(z);
        q.push_back(z);

        // R2: clean fill and readback
        for (int a = 0; a < DEPTH; a++) step(1, a, rnd(), 0, 0, 0, 0, "R2");
        for (int a = 0; a < 8; a++) step(0, 0, '0, 0, 0, 1, a, "R2");
        // R3: single injection corrected
        for (int a = 8; a < 12; a++) step(1, a, rnd(), 1, 0, 0, 0, "R3");
        for (int a = 8; a < 12; a++) step(0, 0, '0, 0, 0, 1, a, "R3");
        // R4 / R1: double injection detected, upper lanes intact
        step(1, 12, rnd(), 0, 1, 0, 0, "R4");
        idle(1);
        step(0, 0, '0, 0, 0, 1, 12, "R4");
        // R5: both injections -> double
        step(1, 13, rnd(), 1, 1, 0, 0, "R5");
        step(0, 0, '0, 0, 0, 1, 13, "R5");
        // R8: same-edge read and write returns old contents
        step(1, 2, rnd(), 0, 0, 1, 2, "R8");
        step(0, 0, '0, 0, 0, 1, 2, "R8");
        // R9: clean rewrite clears an injected word
        step(1, 8, rnd(), 0, 0, 0, 0, "R9");
        step(1, 12, rnd(), 0, 0, 1, 8, "R9");
        step(0, 0, '0, 0, 0, 1, 12, "R9");
        // R6: gaps and back-to-back reads
        idle(3);
        step(0, 0, '0, 0, 0, 1, 3, "R6");
        idle(2);
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            int  k;
            k = int'($urandom_range(0, 9));
            step($urandom_range(0, 1) == 1, int'($urandom_range(0, DEPTH-1)), rnd(),
                 k == 1, k == 2, $urandom_range(0, 1) == 1,
                 int'($urandom_range(0, DEPTH-1)), "R3");
        end
        idle(3);
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule